// File: doc/BRIEF.md
# Multi-Core Interrupt Router

This block gathers the interrupt sources of a small cluster of processor cores and turns them into one IRQ line and one FIQ line per core. Each core contributes four timer request inputs and four mailbox-pending flags, and it decides through two small enable registers whether each of those eight sources is delivered as IRQ, delivered as FIQ, or masked. Three sources are shared by the whole cluster: a shared IRQ input, a shared FIQ input and a local-timer request. Each of them is steered to exactly one core by a short core-index routing field.

Software sees a 32-bit register port that completes in a single cycle. Through it, software programs the routing and enable registers and reads, for each core, a status word that lists the sources currently asserting that core's IRQ and another that lists those asserting its FIQ. The status words are computed combinationally. The per-core output lines are registered copies of "status word is nonzero", so they are glitch-free and follow any change one clock later. The mailbox storage and the local-timer counter sit outside this block and supply only their pending levels.

Top module: `core_irq_router`

## Requirements
- R1: A status word places the four timer sources of its core at bits 0 to 3 (timer n at bit n), mailboxes 0 to 3 of that core at bits 4 to 7, the shared interrupt at bit 8 and the local timer at bit 11. All other bits read as zero.
- R2: For a per-core source n (0 to 3), bit n+4 of its enable register sends it to FIQ, and bit n sends it to IRQ only when bit n+4 is clear. With neither bit set the source appears in no status word. The timer sources use the timer enable register and the mailbox sources use the mailbox enable register.
- R3: The shared-route register holds the IRQ target core in bits 1:0 and the FIQ target core in bits 3:2. The shared IRQ input sets bit 8 of the IRQ status of the IRQ target core only, and the shared FIQ input sets bit 8 of the FIQ status of the FIQ target core only.
- R4: The local-timer route register holds a core index in bits 1:0 and a class select in bit 2 (1 = FIQ, 0 = IRQ). A local-timer request sets bit 11 of that core's FIQ or IRQ status word and of no other word.
- R5: The register map uses byte offsets. The shared route is at 0x0C and the local-timer route is at 0x24. The timer enable registers are at 0x40+4·core and the mailbox enable registers at 0x50+4·core. IRQ status is at 0x60+4·core and FIQ status at 0x70+4·core, both read-only. Read data is returned combinationally in the cycle in which `bus_valid` is high and `bus_write` is low.
- R6: Writes keep only the implemented low bits: 8 bits for the enable registers, 4 bits for the shared route and 3 bits for the local-timer route. A read returns exactly those bits, with zeros above them.
- R7: A core's IRQ output is high in the cycle after its IRQ status word is nonzero, and low in the cycle after it is zero. The FIQ output follows the FIQ status word in the same way.
- R8: A read of an unmapped or misaligned offset returns zero. A write to one of those offsets, or to a status register, changes no register and no output.
- R9: A synchronous active-low reset clears every routing and enable register to zero and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| tmr_req | input | 4·NUM_CORES | Timer requests, core c at bits 4c+3:4c |
| mbx_pend | input | 4·NUM_CORES | Mailbox pending flags, core c at bits 4c+3:4c |
| shared_irq | input | 1 | Shared interrupt, IRQ class |
| shared_fiq | input | 1 | Shared interrupt, FIQ class |
| ltimer_req | input | 1 | Local-timer request |
| core_irq | output | NUM_CORES | IRQ line per core |
| core_fiq | output | NUM_CORES | FIQ line per core |

## Verification
Some rules are checked on every cycle by the assertions. These are that a source enabled for FIQ never shows in an IRQ word, that each shared source lands in exactly one status word, that the output lines track their status words one cycle later, that enable writes keep their low byte, and that unmapped accesses read zero and leave the configuration untouched. The exact bit position of each source, the full enable encoding across all 256 values, every routing combination, the register-map readback and the effect of a mid-run reset are shown only by the bench's sweeps, which compare against a model of the requirements.

// File: rtl/core_irq_pkg.sv
// Shared constants for the interrupt router: status-word bit positions,
// register-map offsets and field widths. Assumes at most four cores, since
// each per-core register bank spans 16 bytes.
package core_irq_pkg;
    localparam int LOCAL_SRCS = 4;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int ROUTE_W    = 2;
    localparam int EN_W       = 2 * LOCAL_SRCS;

    localparam int BIT_TMR0   = 0;
    localparam int BIT_MBX0   = 4;
    localparam int BIT_SHARED = 8;
    localparam int BIT_LTIMER = 11;

    localparam logic [ADDR_W-1:0] OFS_SHARED_ROUTE = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_LT_ROUTE     = 8'h24;
    localparam logic [3:0]        BANK_TMR_EN      = 4'h4;
    localparam logic [3:0]        BANK_MBX_EN      = 4'h5;
    localparam logic [3:0]        BANK_IRQ_ST      = 4'h6;
    localparam logic [3:0]        BANK_FIQ_ST      = 4'h7;

    typedef logic [EN_W-1:0]   en_reg_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cir_en_split.sv
// Splits N pending sources into IRQ and FIQ requests by an enable register.
// Bit n enables IRQ and bit n+N enables FIQ; FIQ takes precedence.
// Purely combinational.
module cir_en_split #(
    parameter int N = 4
) (
    input  logic [2*N-1:0] en,
    input  logic [N-1:0]   pend,
    output logic [N-1:0]   to_irq,
    output logic [N-1:0]   to_fiq
);
    for (genvar j = 0; j < N; j++) begin : g_src
        // one source: FIQ enable dominates, IRQ only when FIQ is off
        always_comb begin
            to_fiq[j] = pend[j] & en[N+j];
            to_irq[j] = pend[j] & en[j] & ~en[N+j];
        end
    end
endmodule

// File: rtl/cir_lane.sv
// One core's slice of the router: builds the IRQ and FIQ status words from
// the core's local sources and the shared routes, and registers the two
// output lines. Assumes route fields are ROUTE_W bits wide.
module cir_lane
    import core_irq_pkg::*;
#(
    parameter int CORE_IDX = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  en_reg_t               tmr_en,
    input  en_reg_t               mbx_en,
    input  logic [LOCAL_SRCS-1:0] tmr_req,
    input  logic [LOCAL_SRCS-1:0] mbx_pend,
    input  logic                  shared_irq,
    input  logic                  shared_fiq,
    input  logic [ROUTE_W-1:0]    shared_irq_tgt,
    input  logic [ROUTE_W-1:0]    shared_fiq_tgt,
    input  logic                  ltimer_req,
    input  logic [ROUTE_W:0]      lt_route,
    output word_t                 irq_word,
    output word_t                 fiq_word,
    output logic                  irq_o,
    output logic                  fiq_o
);
    localparam logic [ROUTE_W-1:0] MY_IDX = ROUTE_W'(CORE_IDX);

    logic [LOCAL_SRCS-1:0] tmr_irq, tmr_fiq, mbx_irq, mbx_fiq;
    logic                  lt_here;

    cir_en_split #(.N(LOCAL_SRCS)) u_tmr (
        .en(tmr_en), .pend(tmr_req), .to_irq(tmr_irq), .to_fiq(tmr_fiq)
    );
    cir_en_split #(.N(LOCAL_SRCS)) u_mbx (
        .en(mbx_en), .pend(mbx_pend), .to_irq(mbx_irq), .to_fiq(mbx_fiq)
    );

    // decide whether the local-timer request is routed to this core
    always_comb lt_here = ltimer_req && (lt_route[ROUTE_W-1:0] == MY_IDX);

    // assemble both status words at their fixed bit positions
    always_comb begin
        irq_word = '0;
        fiq_word = '0;
        irq_word[BIT_TMR0 +: LOCAL_SRCS] = tmr_irq;
        fiq_word[BIT_TMR0 +: LOCAL_SRCS] = tmr_fiq;
        irq_word[BIT_MBX0 +: LOCAL_SRCS] = mbx_irq;
        fiq_word[BIT_MBX0 +: LOCAL_SRCS] = mbx_fiq;
        irq_word[BIT_SHARED] = shared_irq && (shared_irq_tgt == MY_IDX);
        fiq_word[BIT_SHARED] = shared_fiq && (shared_fiq_tgt == MY_IDX);
        irq_word[BIT_LTIMER] = lt_here && !lt_route[ROUTE_W];
        fiq_word[BIT_LTIMER] = lt_here && lt_route[ROUTE_W];
    end

    // register the output lines so they cannot glitch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |irq_word;
            fiq_o <= |fiq_word;
        end
    end

    for (genvar j = 0; j < LOCAL_SRCS; j++) begin : g_chk
        // R2
        tmr_fiq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_en[LOCAL_SRCS+j] |-> !irq_word[BIT_TMR0+j]);
        // R2
        mbx_fiq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mbx_en[LOCAL_SRCS+j] |-> !irq_word[BIT_MBX0+j]);
    end

    // R1
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_word[WORD_W-1:BIT_LTIMER+1] == '0) && (fiq_word[BIT_LTIMER-1:BIT_SHARED+1] == '0));
    // R7
    irq_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_word != '0) |=> irq_o);
    // R7
    irq_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_word == '0) |=> !irq_o);
    // R7
    fiq_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_word != '0) |=> fiq_o);
    // R7
    fiq_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_word == '0) |=> !fiq_o);
endmodule

// File: rtl/cir_regbank.sv
// Register bank of the router: decodes single-cycle 32-bit accesses, holds
// the routing and enable registers, and returns read data combinationally.
// Assumes 32-bit aligned offsets; misaligned or unmapped ones are ignored.
module cir_regbank
    import core_irq_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_valid,
    input  logic                             bus_write,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  word_t                            bus_wdata,
    output word_t                            bus_rdata,
    input  logic [NUM_CORES-1:0][WORD_W-1:0] irq_words,
    input  logic [NUM_CORES-1:0][WORD_W-1:0] fiq_words,
    output logic [NUM_CORES-1:0][EN_W-1:0]   tmr_en_q,
    output logic [NUM_CORES-1:0][EN_W-1:0]   mbx_en_q,
    output logic [ROUTE_W-1:0]               shared_irq_tgt_q,
    output logic [ROUTE_W-1:0]               shared_fiq_tgt_q,
    output logic [ROUTE_W:0]                 lt_route_q
);
    localparam int IDX_W = 2;

    logic             aligned, idx_ok, rd_en, wr_en;
    logic [3:0]       bank;
    logic [IDX_W-1:0] idx;
    logic             hit_shared, hit_lt, hit_tmr, hit_mbx, hit_irq, hit_fiq;
    logic             cfg_hit;

    // split the offset into bank and core index and classify it
    always_comb begin
        aligned    = (bus_addr[1:0] == 2'b00);
        bank       = bus_addr[7:4];
        idx        = bus_addr[3:2];
        idx_ok     = (int'(idx) < NUM_CORES);
        rd_en      = bus_valid && !bus_write;
        wr_en      = bus_valid && bus_write;
        hit_shared = (bus_addr == OFS_SHARED_ROUTE);
        hit_lt     = (bus_addr == OFS_LT_ROUTE);
        hit_tmr    = aligned && idx_ok && (bank == BANK_TMR_EN);
        hit_mbx    = aligned && idx_ok && (bank == BANK_MBX_EN);
        hit_irq    = aligned && idx_ok && (bank == BANK_IRQ_ST);
        hit_fiq    = aligned && idx_ok && (bank == BANK_FIQ_ST);
        cfg_hit    = hit_shared || hit_lt || hit_tmr || hit_mbx;
    end

    // store writes into the implemented low bits of each register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_en_q         <= '0;
            mbx_en_q         <= '0;
            shared_irq_tgt_q <= '0;
            shared_fiq_tgt_q <= '0;
            lt_route_q       <= '0;
        end else if (wr_en) begin
            if (hit_shared) begin
                shared_irq_tgt_q <= bus_wdata[ROUTE_W-1:0];
                shared_fiq_tgt_q <= bus_wdata[2*ROUTE_W-1:ROUTE_W];
            end
            if (hit_lt)  lt_route_q    <= bus_wdata[ROUTE_W:0];
            if (hit_tmr) tmr_en_q[idx] <= bus_wdata[EN_W-1:0];
            if (hit_mbx) mbx_en_q[idx] <= bus_wdata[EN_W-1:0];
        end
    end

    // select the read data for the addressed register, zero otherwise
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (hit_shared)   bus_rdata[2*ROUTE_W-1:0] = {shared_fiq_tgt_q, shared_irq_tgt_q};
            else if (hit_lt)  bus_rdata[ROUTE_W:0]     = lt_route_q;
            else if (hit_tmr) bus_rdata[EN_W-1:0]      = tmr_en_q[idx];
            else if (hit_mbx) bus_rdata[EN_W-1:0]      = mbx_en_q[idx];
            else if (hit_irq) bus_rdata                = irq_words[idx];
            else if (hit_fiq) bus_rdata                = fiq_words[idx];
        end
    end

    logic [2*NUM_CORES*EN_W+2*ROUTE_W+ROUTE_W:0] cfg_flat;
    // gather all configuration state for the stability check
    always_comb cfg_flat = {tmr_en_q, mbx_en_q, shared_irq_tgt_q, shared_fiq_tgt_q, lt_route_q};

    // R8
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !cfg_hit && !hit_irq && !hit_fiq) |-> (bus_rdata == '0));
    // R8
    unmapped_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_hit) |=> $stable(cfg_flat));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        // R6
        tmr_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && bus_addr == ADDR_W'(8'h40 + 4*c)) |=> (tmr_en_q[c] == $past(bus_wdata[EN_W-1:0])));
        // R6
        mbx_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && bus_addr == ADDR_W'(8'h50 + 4*c)) |=> (mbx_en_q[c] == $past(bus_wdata[EN_W-1:0])));
    end
endmodule

// File: rtl/core_irq_router.sv
// Top of the multi-core interrupt router: one register bank plus one lane
// per core. Assumes NUM_CORES is between 1 and 4.
module core_irq_router
    import core_irq_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_valid,
    input  logic                            bus_write,
    input  logic [7:0]                      bus_addr,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    input  logic [NUM_CORES*LOCAL_SRCS-1:0] tmr_req,
    input  logic [NUM_CORES*LOCAL_SRCS-1:0] mbx_pend,
    input  logic                            shared_irq,
    input  logic                            shared_fiq,
    input  logic                            ltimer_req,
    output logic [NUM_CORES-1:0]            core_irq,
    output logic [NUM_CORES-1:0]            core_fiq
);
    logic [NUM_CORES-1:0][WORD_W-1:0] irq_words, fiq_words;
    logic [NUM_CORES-1:0][EN_W-1:0]   tmr_en_q, mbx_en_q;
    logic [ROUTE_W-1:0]               shared_irq_tgt, shared_fiq_tgt;
    logic [ROUTE_W:0]                 lt_route;
    logic [NUM_CORES-1:0]             col_sh_irq, col_sh_fiq, col_lt_irq, col_lt_fiq;

    cir_regbank #(.NUM_CORES(NUM_CORES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_words(irq_words), .fiq_words(fiq_words),
        .tmr_en_q(tmr_en_q), .mbx_en_q(mbx_en_q),
        .shared_irq_tgt_q(shared_irq_tgt), .shared_fiq_tgt_q(shared_fiq_tgt),
        .lt_route_q(lt_route)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
        cir_lane #(.CORE_IDX(c)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .tmr_en(tmr_en_q[c]), .mbx_en(mbx_en_q[c]),
            .tmr_req(tmr_req[c*LOCAL_SRCS +: LOCAL_SRCS]),
            .mbx_pend(mbx_pend[c*LOCAL_SRCS +: LOCAL_SRCS]),
            .shared_irq(shared_irq), .shared_fiq(shared_fiq),
            .shared_irq_tgt(shared_irq_tgt), .shared_fiq_tgt(shared_fiq_tgt),
            .ltimer_req(ltimer_req), .lt_route(lt_route),
            .irq_word(irq_words[c]), .fiq_word(fiq_words[c]),
            .irq_o(core_irq[c]), .fiq_o(core_fiq[c])
        );
        // collect the shared-source columns across lanes for the checks
        always_comb begin
            col_sh_irq[c] = irq_words[c][BIT_SHARED];
            col_sh_fiq[c] = fiq_words[c][BIT_SHARED];
            col_lt_irq[c] = irq_words[c][BIT_LTIMER];
            col_lt_fiq[c] = fiq_words[c][BIT_LTIMER];
        end
    end

    // R3
    shared_irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(col_sh_irq) == int'(shared_irq)) && $onehot0(col_sh_irq));
    // R3
    shared_fiq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(col_sh_fiq) == int'(shared_fiq)));
    // R4
    ltimer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({col_lt_irq, col_lt_fiq}) == int'(ltimer_req)));
endmodule

// File: tb/sim_core_irq_router.sv
module sim_core_irq_router;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] tmr_req = '0, mbx_pend = '0;
    logic        shared_irq = 1'b0, shared_fiq = 1'b0, ltimer_req = 1'b0;
    logic [NC-1:0] core_irq, core_fiq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [7:0] m_tmr[NC], m_mbx[NC];
    logic [1:0] m_sirq, m_sfiq;
    logic [2:0] m_lt;

    core_irq_router #(.NUM_CORES(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_req(tmr_req), .mbx_pend(mbx_pend), .shared_irq(shared_irq),
        .shared_fiq(shared_fiq), .ltimer_req(ltimer_req),
        .core_irq(core_irq), .core_fiq(core_fiq));

    always #4ns clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // model of a status word from the requirements (f=1 for FIQ)
    function automatic logic [31:0] exp_word(int c, bit f);
        logic [31:0] w = '0;
        for (int j = 0; j < 4; j++) begin
            if (tmr_req[4*c+j]) w[j]   = f ? m_tmr[c][j+4] : (m_tmr[c][j] && !m_tmr[c][j+4]);
            if (mbx_pend[4*c+j]) w[4+j] = f ? m_mbx[c][j+4] : (m_mbx[c][j] && !m_mbx[c][j+4]);
        end
        if (!f && shared_irq && int'(m_sirq) == c) w[8] = 1'b1;
        if (f && shared_fiq && int'(m_sfiq) == c) w[8] = 1'b1;
        if (ltimer_req && int'(m_lt[1:0]) == c && m_lt[2] == f) w[11] = 1'b1;
        return w;
    endfunction

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1ns d = bus_rdata;
        bus_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic check_lines(string req);
        logic [NC-1:0] ei, ef;
        for (int c = 0; c < NC; c++) begin
            ei[c] = exp_word(c, 0) != 0;
            ef[c] = exp_word(c, 1) != 0;
        end
        check(req, {24'b0, core_fiq, core_irq}, {24'b0, ef, ei});
    endtask

    task automatic check_status(string req, int c);
        logic [31:0] d;
        rd(8'(8'h60 + 4*c), d); check(req, d, exp_word(c, 0));
        rd(8'(8'h70 + 4*c), d); check(req, d, exp_word(c, 1));
    endtask

    task automatic clear_model();
        for (int c = 0; c < NC; c++) begin m_tmr[c] = '0; m_mbx[c] = '0; end
        m_sirq = '0; m_sfiq = '0; m_lt = '0;
    endtask

    initial begin
        #(8ns * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R9: reset state of outputs and registers
        check("R9 lines", {24'b0, core_fiq, core_irq}, 32'h0);
        rd(8'h0C, d); check("R9 shared route", d, 0);
        rd(8'h24, d); check("R9 lt route", d, 0);
        for (int c = 0; c < NC; c++) begin
            rd(8'(8'h40 + 4*c), d); check("R9 tmr en", d, 0);
            rd(8'(8'h50 + 4*c), d); check("R9 mbx en", d, 0);
        end

        // R1 R2 R7: sweep every timer enable value under 16 request patterns
        for (int v = 0; v < 256; v++) begin
            for (int c = 0; c < NC; c++) begin
                m_tmr[c] = 8'(v + 67 * c);
                wr(8'(8'h40 + 4*c), {24'hA5A5A5, m_tmr[c]});
            end
            for (int p = 0; p < 16; p++) begin
                for (int c = 0; c < NC; c++) tmr_req[4*c +: 4] = 4'(p + 5 * c);
                settle();
                check_lines("R7 timer lines");
                check_status("R2 timer status", p % NC);
            end
        end
        tmr_req = '0;

        // R1 R2 R7: same sweep over the mailbox enables
        for (int v = 0; v < 256; v++) begin
            for (int c = 0; c < NC; c++) begin
                m_mbx[c] = 8'(v * 3 + 41 * c);
                wr(8'(8'h50 + 4*c), {24'h5A5A5A, m_mbx[c]});
            end
            for (int p = 0; p < 16; p++) begin
                for (int c = 0; c < NC; c++) mbx_pend[4*c +: 4] = 4'(p + 7 * c);
                settle();
                check_lines("R7 mailbox lines");
                check_status("R2 mailbox status", (p + 1) % NC);
            end
        end
        mbx_pend = '0;
        for (int c = 0; c < NC; c++) begin m_tmr[c] = 0; m_mbx[c] = 0; wr(8'(8'h40 + 4*c), 0); wr(8'(8'h50 + 4*c), 0); end

        // R3: every shared route under every shared input combination
        for (int r = 0; r < 16; r++) begin
            m_sirq = r[1:0]; m_sfiq = r[3:2];
            wr(8'h0C, 32'(r));
            for (int s = 0; s < 4; s++) begin
                shared_irq = s[0]; shared_fiq = s[1];
                settle();
                check_lines("R3 shared lines");
                for (int c = 0; c < NC; c++) check_status("R3 shared status", c);
            end
        end
        shared_irq = 0; shared_fiq = 0;

        // R4: every local-timer route with and without a request
        for (int r = 0; r < 8; r++) begin
            m_lt = 3'(r);
            wr(8'h24, 32'(r));
            for (int s = 0; s < 2; s++) begin
                ltimer_req = s[0];
                settle();
                check_lines("R4 ltimer lines");
                for (int c = 0; c < NC; c++) check_status("R4 ltimer status", c);
            end
        end

        // R1: combined layout on core 1 with fixed expected words
        m_tmr[1] = 8'h0F; wr(8'h44, 32'h0F);
        m_mbx[1] = 8'hF0; wr(8'h54, 32'hF0);
        m_sirq = 1; m_sfiq = 2; wr(8'h0C, 32'h9);
        m_lt = 3'd1; wr(8'h24, 32'h1);
        tmr_req = '1; mbx_pend = '1; shared_irq = 1; ltimer_req = 1;
        settle();
        rd(8'h64, d); check("R1 irq layout", d, 32'h0000090F);
        rd(8'h74, d); check("R1 fiq layout", d, 32'h000000F0);

        // R5 R6: readback keeps only the implemented low bits
        wr(8'h48, 32'hFFFFFF5A); m_tmr[2] = 8'h5A;
        wr(8'h5C, 32'hABCDEF3C); m_mbx[3] = 8'h3C;
        wr(8'h0C, 32'hFFFFFFF6); m_sirq = 2; m_sfiq = 1;
        wr(8'h24, 32'hFFFFFFFD); m_lt = 3'd5;
        rd(8'h48, d); check("R6 tmr en trunc", d, 32'h5A);
        rd(8'h5C, d); check("R6 mbx en trunc", d, 32'h3C);
        rd(8'h0C, d); check("R6 shared route trunc", d, 32'h6);
        rd(8'h24, d); check("R6 lt route trunc", d, 32'h5);
        settle();
        check_lines("R5 lines after map writes");
        for (int c = 0; c < NC; c++) check_status("R5 status map", c);

        // R8: unmapped, misaligned and read-only writes change nothing
        begin
            logic [NC-1:0] li, lf;
            logic [7:0] bad[8] = '{8'h00, 8'h10, 8'h38, 8'h42, 8'h60, 8'h74, 8'h80, 8'hFC};
            li = core_irq; lf = core_fiq;
            foreach (bad[k]) begin
                wr(bad[k], 32'hFFFFFFFF);
                settle();
                check("R8 lines unchanged", {24'b0, core_fiq, core_irq}, {24'b0, lf, li});
            end
            rd(8'h48, d); check("R8 tmr en kept", d, 32'h5A);
            rd(8'h0C, d); check("R8 shared route kept", d, 32'h6);
            rd(8'h24, d); check("R8 lt route kept", d, 32'h5);
            rd(8'h40, d); check("R8 tmr en0 kept", d, {24'b0, m_tmr[0]});
            foreach (bad[k]) if (bad[k] < 8'h40 || bad[k] >= 8'h80 || bad[k][1:0] != 0) begin
                rd(bad[k], d); check("R8 unmapped read", d, 0);
            end
        end

        // R9: mid-run reset clears configuration and lines
        shared_irq = 0; shared_fiq = 0; ltimer_req = 0;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        check("R9 lines after reset", {24'b0, core_fiq, core_irq}, 32'h0);
        rd(8'h48, d); check("R9 tmr en cleared", d, 0);
        rd(8'h5C, d); check("R9 mbx en cleared", d, 0);
        rd(8'h0C, d); check("R9 shared route cleared", d, 0);
        rd(8'h24, d); check("R9 lt route cleared", d, 0);
        settle();
        check_lines("R9 masked sources");

        done = 1;
        finish_run();
    end
endmodule